// File: doc/BRIEF.md
# Branch and Jump Target Unit

This combinational unit chooses the next program counter for a 16-bit load/store processor. Memory is byte-addressed, and instructions sit on even addresses. The unit takes four inputs: the incremented PC, which is the address of the instruction after the current one; the current instruction word; a base register value that the register file has already read; and the three condition flags (negative, zero, positive). It returns the next fetch address and a flag that says whether control flow was redirected.

It handles four cases:
- **Conditional branch.** The unit tests the instruction's flag mask against the current condition flags. If any masked flag is set, it adds a doubled, sign-extended 9-bit offset to the incremented PC.
- **Register-indirect jump.** This also covers subroutine return, which is the same opcode with register 7 as the base. The unit passes the base value through and ignores the PC.
- **Address computation.** The same PC-relative sum goes out on a separate effective-address port, and sequential flow continues.
- **Any other opcode.** The unit continues sequentially.

Top module: `brtgt_unit`

## Requirements
- R1: Opcode instr[15:12]=0000 is a conditional branch. When it is taken, next_pc equals pc_inc plus the 9-bit field instr[8:0], sign-extended and multiplied by two, wrapping modulo 2^16.
- R2: A branch is taken when its mask instr[11:9] (bit 11 tests n, bit 10 tests z, bit 9 tests p) shares a set bit with cc_i = {n,z,p}. When it is not taken, next_pc equals pc_inc and taken is 0.
- R3: A branch whose mask is 000 is never taken, whatever the flags are.
- R4: A branch whose mask is 111 is always taken. With offset 0x1FF (-1), its target is the branch's own address, pc_inc-2, which forms a halt loop.
- R5: Opcode 1100 is a register jump. next_pc equals base_i with bit 0 cleared and taken is 1. pc_inc has no effect on either.
- R6: Return is opcode 1100 with base field instr[8:6]=111. It is decoded no differently and yields the same result as any other jump on base_i.
- R7: Opcode 1110 is an address computation. ea equals pc_inc plus the doubled, sign-extended instr[8:0]. next_pc equals pc_inc and taken is 0.
- R8: Every other opcode gives next_pc equal to pc_inc and taken equal to 0.
- R9: Bit 0 of next_pc and bit 0 of ea are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_inc_i | input | 16 | Address of the following instruction (current PC + 2) |
| instr_i | input | 16 | Current instruction word |
| base_i | input | 16 | Base register value read for jumps |
| cc_i | input | 3 | Condition flags {n,z,p} |
| next_pc_o | output | 16 | Next fetch address |
| taken_o | output | 1 | Control flow redirected |
| ea_o | output | 16 | PC-relative effective address |

## Verification
The bound checker evaluates its properties whenever any input changes:
- outputs stay word-aligned;
- a taken branch always has at least one masked flag set;
- an empty mask never redirects and a full mask always does;
- a jump always reflects the base value;
- the untaken path always returns the incremented PC.

Some properties can only be shown by the bench's scenarios. These are:
- exact offset arithmetic, including sign extension and wraparound at both ends of the offset range;
- the halt-loop target;
- the fact that the PC has no effect on jumps, which needs the same jump presented with two different PC values;
- the equivalence of return and jump.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
    localparam int ILEN  = 16;
    localparam int OPW   = 4;
    localparam int OFFW  = 9;
    localparam int MASKW = 3;

    localparam logic [OPW-1:0] OPC_BR  = 4'b0000;
    localparam logic [OPW-1:0] OPC_JMP = 4'b1100;
    localparam logic [OPW-1:0] OPC_LEA = 4'b1110;

    typedef enum logic [1:0] {
        K_SEQ = 2'd0,
        K_BR  = 2'd1,
        K_JMP = 2'd2,
        K_LEA = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [MASKW-1:0]  mask;
        logic [OFFW-1:0]   off;
    } dec_t;
endpackage

// File: rtl/brtgt_decode.sv
module brtgt_decode
    import brtgt_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output dec_t            dec_o
);
    localparam int OP_HI   = ILEN - 1;
    localparam int OP_LO   = ILEN - OPW;
    localparam int MASK_HI = OP_LO - 1;
    localparam int MASK_LO = OP_LO - MASKW;

    always_comb begin
        dec_o.mask = instr_i[MASK_HI:MASK_LO];
        dec_o.off  = instr_i[OFFW-1:0];
        case (instr_i[OP_HI:OP_LO])
            OPC_BR:  dec_o.kind = K_BR;
            OPC_JMP: dec_o.kind = K_JMP;
            OPC_LEA: dec_o.kind = K_LEA;
            default: dec_o.kind = K_SEQ;
        endcase
    end
endmodule

// File: rtl/brtgt_cond.sv
module brtgt_cond
    import brtgt_pkg::*;
(
    input  logic [MASKW-1:0] mask_i,
    input  logic [MASKW-1:0] cc_i,
    output logic             hit_o
);
    logic [MASKW-1:0] match;

    for (genvar g = 0; g < MASKW; g++) begin : g_flag
        assign match[g] = mask_i[g] & cc_i[g];
    end

    assign hit_o = |match;
endmodule

// File: rtl/brtgt_reladd.sv
module brtgt_reladd #(
    parameter int XLEN = 16,
    parameter int OFFW = 9
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [OFFW-1:0] off_i,
    output logic [XLEN-1:0] sum_o
);
    localparam int EXTW = XLEN - OFFW - 1;

    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] raw;

    assign scaled = {{EXTW{off_i[OFFW-1]}}, off_i, 1'b0};
    assign raw    = pc_i + scaled;
    assign sum_o  = {raw[XLEN-1:1], 1'b0};
endmodule

// File: rtl/brtgt_unit.sv
module brtgt_unit
    import brtgt_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0]  pc_inc_i,
    input  logic [ILEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  base_i,
    input  logic [MASKW-1:0] cc_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             taken_o,
    output logic [XLEN-1:0]  ea_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            taken;
    } nxt_t;

    dec_t            dec;
    logic            hit;
    logic [XLEN-1:0] rel_sum;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] jmp_pc;
    nxt_t            nxt_d;

    brtgt_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    brtgt_cond u_cond (
        .mask_i (dec.mask),
        .cc_i   (cc_i),
        .hit_o  (hit)
    );

    brtgt_reladd #(.XLEN(XLEN), .OFFW(OFFW)) u_add (
        .pc_i  (pc_inc_i),
        .off_i (dec.off),
        .sum_o (rel_sum)
    );

    assign seq_pc = {pc_inc_i[XLEN-1:1], 1'b0};
    assign jmp_pc = {base_i[XLEN-1:1], 1'b0};

    always_comb begin
        nxt_d.pc    = seq_pc;
        nxt_d.taken = 1'b0;
        case (dec.kind)
            K_BR: begin
                if (hit) begin
                    nxt_d.pc    = rel_sum;
                    nxt_d.taken = 1'b1;
                end
            end
            K_JMP: begin
                nxt_d.pc    = jmp_pc;
                nxt_d.taken = 1'b1;
            end
            default: ;
        endcase
    end

    assign next_pc_o = nxt_d.pc;
    assign taken_o   = nxt_d.taken;
    assign ea_o      = rel_sum;
endmodule

// File: rtl/brtgt_unit_chk.sv
module brtgt_unit_chk #(
    parameter int XLEN = 16
) (
    input logic [XLEN-1:0] pc_inc_i,
    input logic [15:0]     instr_i,
    input logic [XLEN-1:0] base_i,
    input logic [2:0]      cc_i,
    input logic [XLEN-1:0] next_pc_o,
    input logic            taken_o,
    input logic [XLEN-1:0] ea_o
);
    logic is_br, is_jmp, is_lea;
    assign is_br  = (instr_i[15:12] == 4'b0000);
    assign is_jmp = (instr_i[15:12] == 4'b1100);
    assign is_lea = (instr_i[15:12] == 4'b1110);

    always_comb begin
        AST_PC_ALIGNED: assert (next_pc_o[0] == 1'b0) else $error("next pc odd"); // R9
        AST_EA_ALIGNED: assert (ea_o[0] == 1'b0) else $error("ea odd"); // R9
        AST_BR_NEEDS_FLAG: assert (!(is_br && taken_o) || ((instr_i[11:9] & cc_i) != 3'b000)) else $error("taken without flag"); // R2
        AST_EMPTY_MASK: assert (!(is_br && instr_i[11:9] == 3'b000) || !taken_o) else $error("empty mask taken"); // R3
        AST_FULL_MASK: assert (!(is_br && instr_i[11:9] == 3'b111 && cc_i != 3'b000) || taken_o) else $error("full mask not taken"); // R4
        AST_JMP_BASE: assert (!is_jmp || (taken_o && next_pc_o[XLEN-1:1] == base_i[XLEN-1:1])) else $error("jump target"); // R5
        AST_LEA_SEQ: assert (!is_lea || !taken_o) else $error("lea redirected"); // R7
        AST_UNTAKEN_SEQ: assert (taken_o || next_pc_o[XLEN-1:1] == pc_inc_i[XLEN-1:1]) else $error("untaken not sequential"); // R8
    end
endmodule

bind brtgt_unit brtgt_unit_chk #(.XLEN(XLEN)) u_chk (
    .pc_inc_i  (pc_inc_i),
    .instr_i   (instr_i),
    .base_i    (base_i),
    .cc_i      (cc_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o),
    .ea_o      (ea_o)
);

// File: tb/brtgt_unit_tb_top.sv
module brtgt_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pc_inc, instr, base, next_pc, ea;
    logic [2:0]  cc;
    logic        taken;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brtgt_unit dut_i (
        .pc_inc_i  (pc_inc),
        .instr_i   (instr),
        .base_i    (base),
        .cc_i      (cc),
        .next_pc_o (next_pc),
        .taken_o   (taken),
        .ea_o      (ea)
    );

    function automatic logic [15:0] rel(input logic [15:0] pc, input logic [8:0] f);
        int o;
        o = f[8] ? int'(f) - 512 : int'(f);
        return 16'(int'(pc) + 2 * o) & 16'hFFFE;
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h (instr %h pc %h cc %b)", req, got, exp, instr, pc_inc, cc);
        end
    endtask

    task automatic apply(input string req, input logic [15:0] p, input logic [15:0] i,
                         input logic [15:0] b, input logic [2:0] c);
        logic [15:0] e_pc, e_ea;
        logic        e_tk;
        @(posedge clk);
        pc_inc = p; instr = i; base = b; cc = c;
        @(negedge clk);
        e_ea = rel(p, i[8:0]);
        e_pc = p & 16'hFFFE;
        e_tk = 1'b0;
        if (i[15:12] == 4'b0000 && (i[11:9] & c) != 3'b000) begin
            e_pc = e_ea; e_tk = 1'b1;
        end else if (i[15:12] == 4'b1100) begin
            e_pc = b & 16'hFFFE; e_tk = 1'b1;
        end
        chk({req, " pc"}, next_pc, e_pc);
        chk({req, " taken"}, {15'd0, taken}, {15'd0, e_tk});
        chk({req, " ea"}, ea, e_ea);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        pc_inc = '0; instr = '0; base = '0; cc = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset", next_pc, 16'h0000);
        chk("R3 reset taken", {15'd0, taken}, 16'h0000);
        // R2 single-flag masks against each flag
        for (int m = 0; m < 8; m++)
            for (int c = 1; c < 8; c *= 2)
                apply("R2 mask", 16'h3000, {4'b0000, 3'(m), 9'h010}, 16'h0, 3'(c));
        // R3 empty mask with all flags
        apply("R3 empty", 16'h1234, {4'b0000, 3'b000, 9'h005}, 16'h0, 3'b111);
        // R4 halt loop
        apply("R4 halt", 16'h0402, {4'b0000, 3'b111, 9'h1FF}, 16'h0, 3'b010);
        chk("R4 self", next_pc, 16'h0400);
        // R1 offset extremes and wrap
        apply("R1 maxpos", 16'h1000, {4'b0000, 3'b001, 9'h0FF}, 16'h0, 3'b001);
        chk("R1 maxpos value", next_pc, 16'h11FE);
        apply("R1 minneg wrap", 16'h0010, {4'b0000, 3'b100, 9'h100}, 16'h0, 3'b100);
        chk("R1 wrap value", next_pc, 16'hFE10);
        apply("R1 high wrap", 16'hFFF0, {4'b0000, 3'b010, 9'h020}, 16'h0, 3'b010);
        // R5 jump ignores pc
        apply("R5 jmp a", 16'h2000, {4'b1100, 3'b000, 3'b010, 6'h0}, 16'hABCD, 3'b000);
        chk("R5 jmp value", next_pc, 16'hABCC);
        apply("R5 jmp b", 16'h7FFE, {4'b1100, 3'b000, 3'b010, 6'h0}, 16'hABCD, 3'b101);
        chk("R5 pc-free", next_pc, 16'hABCC);
        // R6 return
        apply("R6 ret", 16'h0200, {4'b1100, 3'b000, 3'b111, 6'h0}, 16'h0C46, 3'b010);
        chk("R6 ret value", next_pc, 16'h0C46);
        // R7 address computation
        apply("R7 lea", 16'h0500, {4'b1110, 3'b011, 9'h1F0}, 16'h0, 3'b111);
        chk("R7 lea value", ea, 16'h04E0);
        // R8 other opcodes
        for (int op = 1; op < 16; op++)
            if (op != 12 && op != 14)
                apply("R8 other", 16'h4444, {4'(op), 12'hFFF}, 16'h8888, 3'b111);
        // R9 random sweep including odd base
        for (int k = 0; k < 400; k++)
            apply("R9 rand", 16'($urandom) & 16'hFFFE, 16'($urandom), 16'($urandom), 3'($urandom));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule